// File: doc/BRIEF.md
# Parallel Flash Bus Strobe Interface

This block is the device-side front end of an 8-bit asynchronous parallel flash memory. It samples the active-low chip enable, output enable and write enable strobes, the 17-bit address bus, the 8-bit data bus and a digital flag that reports a high-voltage condition on the control pins. All of these pass through two-flop synchronizers into a fast internal sample clock. From the synchronized pins the block reports the current bus mode and drives the tri-state enable of the data bus during valid reads.

A write is the overlap of chip enable low and write enable low while output enable is high. The address is taken when the overlap starts, which is when the later of the two strobes falls. The data is taken when the overlap ends, which is when the earlier of the two strobes rises. Each write that is long enough is passed downstream as one single-cycle pulse carrying the captured address and data. An overlap seen for fewer than `NOISE_CYC` samples is dropped as noise. Writes that are cut short by output enable, or that end while the high-voltage flag is set, are also dropped.

Top module: `pflash_strobe_if`

## Requirements
- R1: After reset `bus_mode_o` is 0 (standby), and `dq_drive_o` and `wr_valid_o` are both 0.
- R2: While chip enable is high, `bus_mode_o` is 0 and `dq_drive_o` is 0, whatever output enable and write enable do.
- R3: With chip enable low, output enable low and write enable high, `bus_mode_o` becomes 2 (read) and `dq_drive_o` becomes 1 no later than three sample cycles after the pins settle. The drive stops when chip enable or output enable returns high.
- R4: If write enable is low at the moment chip enable and output enable are both first seen low, `dq_drive_o` stays 0 for that whole access, even after write enable rises. A new access that begins with write enable high is driven.
- R5: With chip enable low and both output enable and write enable high, `bus_mode_o` is 1 (output disable) and `dq_drive_o` is 0.
- R6: With chip enable low, write enable low and output enable high, `bus_mode_o` is 3 (write). Each accepted write produces exactly one `wr_valid_o` pulse, one cycle wide.
- R7: `wr_addr_o` carries the address present when the later of chip enable or write enable fell. This holds for both writes led by write enable and writes led by chip enable.
- R8: `wr_data_o` carries the data present when the earlier of chip enable or write enable rose.
- R9: Output enable low inhibits a write. If output enable falls while chip enable and write enable are both low, no pulse is produced for that strobe.
- R10: An overlap seen for fewer than `NOISE_CYC` consecutive samples (default 2) produces no pulse. An overlap of exactly `NOISE_CYC` samples is accepted.
- R11: A write whose overlap ends while the high-voltage flag is set produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 17 | Address bus |
| data_i | input | 8 | Incoming data bus |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| hv_i | input | 1 | High-voltage condition flag |
| bus_mode_o | output | 2 | 0 standby, 1 output disable, 2 read, 3 write |
| dq_drive_o | output | 1 | Data bus output-driver enable |
| wr_valid_o | output | 1 | One-cycle accepted-write pulse |
| wr_addr_o | output | 17 | Captured write address |
| wr_data_o | output | 8 | Captured write data |

## Verification
Writes are driven with write enable leading and with chip enable leading. The address bus changes before the later fall and again after it, and the data bus changes before and after the earlier rise, so a capture taken on the wrong edge shows up as a wrong value. Overlaps of 1, 2 and 5 samples separate dropped noise from the exact threshold and from normal writes. Strobes aborted by output enable, and strobes ending under the high-voltage flag, must leave the scoreboard queue untouched. Read sequences that enter with write enable high or low show whether the entry ordering rule is honoured.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_ODIS  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } pfs_mode_e;

  // decode of the three active-low strobes into a bus mode
  function automatic pfs_mode_e pin_mode(input logic ce_n, input logic oe_n,
                                         input logic we_n);
    if (ce_n)               return MODE_STBY;
    if (!oe_n && we_n)      return MODE_READ;
    if (oe_n && !we_n)      return MODE_WRITE;
    return MODE_ODIS;
  endfunction

  // write overlap: chip and write enables low with output enable high
  function automatic logic wr_overlap(input logic ce_n, input logic oe_n,
                                      input logic we_n);
    return !ce_n && !we_n && oe_n;
  endfunction

  // overlap length test against the noise threshold
  function automatic logic long_enough(input int unsigned seen,
                                       input int unsigned need);
    return seen >= need;
  endfunction

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/pfs_mode_decode.sv
module pfs_mode_decode
  import pfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_s,
  input  logic      oe_s,
  input  logic      we_s,
  output pfs_mode_e mode_o,
  output logic      dq_drive_o
);
  logic both_low, both_low_q, read_entry, read_ok_d;

  assign both_low   = !ce_s && !oe_s;
  assign read_entry = both_low && !both_low_q;
  // a read counts only if WE was high on entry and has stayed high
  assign read_ok_d  = both_low && we_s && (read_entry || dq_drive_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_low_q <= 1'b0;
      dq_drive_o <= 1'b0;
      mode_o     <= MODE_STBY;
    end else begin
      both_low_q <= both_low;
      dq_drive_o <= read_ok_d;
      mode_o     <= pin_mode(ce_s, oe_s, we_s);
    end
  end

  // R3
  drive_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive_o |-> mode_o == MODE_READ);
  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == MODE_STBY |-> !dq_drive_o);
  // R4
  no_late_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_drive_o) |-> $past(we_s));
endmodule

// File: rtl/pfs_write_capture.sv
module pfs_write_capture
  import pfs_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int NOISE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          hv_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(NOISE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NOISE_CYC);

  logic          ovl_now, ovl_q, ovl_rise, ovl_fall, strobe_release, accept;
  logic [CNT_W-1:0] seen_cnt;
  logic [AW-1:0] addr_hold;

  assign ovl_now        = wr_overlap(ce_s, oe_s, we_s);
  assign ovl_rise       = ovl_now && !ovl_q;
  assign ovl_fall       = !ovl_now && ovl_q;
  assign strobe_release = ce_s || we_s;
  assign accept         = ovl_fall && strobe_release && !hv_s &&
                          long_enough(int'(seen_cnt), NOISE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q      <= 1'b0;
      seen_cnt   <= '0;
      addr_hold  <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      ovl_q      <= ovl_now;
      wr_valid_o <= accept;
      if (ovl_rise) begin
        seen_cnt  <= CNT_W'(1);
        addr_hold <= addr_s;
      end else if (ovl_now && seen_cnt < CNT_MAX) begin
        seen_cnt <= seen_cnt + CNT_W'(1);
      end
      if (accept) begin
        wr_addr_o <= addr_hold;
        wr_data_o <= data_s;
      end
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  // R11
  hv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(!hv_s));
  // R9
  oe_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(oe_s));
  // R10
  noise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_q) |=> !wr_valid_o);
endmodule

// File: rtl/pflash_strobe_if.sv
module pflash_strobe_if
  import pfs_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int NOISE_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic          hv_i,
  output logic [1:0]    bus_mode_o,
  output logic          dq_drive_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int BW = AW + DW;

  logic [3:0]    ctl_s;
  logic [BW-1:0] bus_s;
  pfs_mode_e     mode;

  // control strobes reset inactive (high), hv flag reset low
  pfs_sync #(.W(4), .RST_VAL(4'b0111)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({hv_i, ce_n_i, oe_n_i, we_n_i}), .q_o(ctl_s));

  // address and data delayed by the same two stages to stay aligned
  pfs_sync #(.W(BW), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({addr_i, data_i}), .q_o(bus_s));

  pfs_mode_decode u_mode (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctl_s[2]), .oe_s(ctl_s[1]), .we_s(ctl_s[0]),
    .mode_o(mode), .dq_drive_o(dq_drive_o));

  pfs_write_capture #(.AW(AW), .DW(DW), .NOISE_CYC(NOISE_CYC)) u_wcap (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ctl_s[2]), .oe_s(ctl_s[1]), .we_s(ctl_s[0]), .hv_s(ctl_s[3]),
    .addr_s(bus_s[BW-1:DW]), .data_s(bus_s[DW-1:0]),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

  assign bus_mode_o = mode;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid_o && !dq_drive_o));
endmodule

// File: tb/pflash_strobe_if_test.sv
`timescale 1ns/1ps
module pflash_strobe_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        ce_n_i = 1'b1, oe_n_i = 1'b1, we_n_i = 1'b1, hv_i = 1'b0;
  logic [1:0]  bus_mode_o;
  logic        dq_drive_o, wr_valid_o;
  logic [16:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  int checks = 0;
  int bad = 0;
  logic [24:0] expq[$];

  always #2 clk = ~clk;

  pflash_strobe_if uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i), .hv_i(hv_i),
    .bus_mode_o(bus_mode_o), .dq_drive_o(dq_drive_o),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o));

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every pulse must match the head of the queue (R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && wr_valid_o) begin
      if (expq.size() == 0) begin
        check("R6 unexpected pulse", {7'd0, wr_addr_o, wr_data_o}, 32'hFFFF_FFFF);
      end else begin
        logic [24:0] e;
        e = expq.pop_front();
        check("R7 address", {15'd0, wr_addr_o}, {15'd0, e[24:8]});
        check("R8 data", {24'd0, wr_data_o}, {24'd0, e[7:0]});
      end
    end
  end

  // driver: ce_ctl=1 means CE falls last and rises first
  task automatic wr_cyc(input bit ce_ctl, input logic [16:0] a,
                        input logic [7:0] d, input int len, input bit hv,
                        input bit exp_ok);
    @(negedge clk);
    if (ce_ctl) we_n_i = 1'b0; else ce_n_i = 1'b0;
    addr_i = ~a; data_i = ~d;
    @(negedge clk);
    if (ce_ctl) ce_n_i = 1'b0; else we_n_i = 1'b0;
    addr_i = a; hv_i = hv;
    data_i = (len == 1) ? d : ~d;
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      addr_i = a ^ 17'h1;
      if (i == len - 1) data_i = d;
    end
    @(negedge clk);
    if (ce_ctl) ce_n_i = 1'b1; else we_n_i = 1'b1;
    if (exp_ok) expq.push_back({a, d});
    @(negedge clk);
    data_i = d ^ 8'h80;
    ce_n_i = 1'b1; we_n_i = 1'b1; hv_i = 1'b0;
    idle(5);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1
    check("R1 mode", {30'd0, bus_mode_o}, 32'd0);
    check("R1 drive", {31'd0, dq_drive_o}, 32'd0);
    check("R1 valid", {31'd0, wr_valid_o}, 32'd0);
    rst_n = 1'b1;
    idle(3);

    // R2 standby with OE low
    oe_n_i = 1'b0; idle(5);
    check("R2 mode", {30'd0, bus_mode_o}, 32'd0);
    check("R2 drive", {31'd0, dq_drive_o}, 32'd0);

    // R3 read
    ce_n_i = 1'b0; idle(4);
    check("R3 mode", {30'd0, bus_mode_o}, 32'd2);
    check("R3 drive", {31'd0, dq_drive_o}, 32'd1);
    // R5 output disable
    oe_n_i = 1'b1; idle(4);
    check("R5 mode", {30'd0, bus_mode_o}, 32'd1);
    check("R5 drive", {31'd0, dq_drive_o}, 32'd0);
    // R3 read ends on CE
    oe_n_i = 1'b0; idle(4);
    check("R3 drive again", {31'd0, dq_drive_o}, 32'd1);
    ce_n_i = 1'b1; idle(4);
    check("R3 CE end", {31'd0, dq_drive_o}, 32'd0);
    check("R2 mode CE high", {30'd0, bus_mode_o}, 32'd0);

    // R4 entry with WE low
    we_n_i = 1'b0; idle(2);
    ce_n_i = 1'b0; idle(4);
    we_n_i = 1'b1; idle(5);
    check("R4 mode", {30'd0, bus_mode_o}, 32'd2);
    check("R4 no drive", {31'd0, dq_drive_o}, 32'd0);
    oe_n_i = 1'b1; idle(3);
    oe_n_i = 1'b0; idle(4);
    check("R4 new access drives", {31'd0, dq_drive_o}, 32'd1);
    oe_n_i = 1'b1; ce_n_i = 1'b1; idle(4);

    // R6 write mode code
    ce_n_i = 1'b0; we_n_i = 1'b0; idle(4);
    check("R6 mode", {30'd0, bus_mode_o}, 32'd3);
    we_n_i = 1'b1; ce_n_i = 1'b1;
    expq.push_back({addr_i, data_i});
    idle(6);

    // R7 R8 both controls, several patterns
    wr_cyc(1'b0, 17'h15555, 8'hAA, 5, 1'b0, 1'b1);
    wr_cyc(1'b1, 17'h0AAAA, 8'h55, 5, 1'b0, 1'b1);
    wr_cyc(1'b0, 17'h1E000, 8'h3C, 3, 1'b0, 1'b1);
    wr_cyc(1'b1, 17'h00001, 8'hC3, 4, 1'b0, 1'b1);
    // R10 threshold
    wr_cyc(1'b0, 17'h12345, 8'h11, 1, 1'b0, 1'b0);
    wr_cyc(1'b1, 17'h0F0F0, 8'h22, 1, 1'b0, 1'b0);
    wr_cyc(1'b0, 17'h1FFFF, 8'h77, 2, 1'b0, 1'b1);
    // R11 high-voltage flag
    wr_cyc(1'b0, 17'h0BEEF, 8'h99, 5, 1'b1, 1'b0);
    check("R11 queue drained", expq.size(), 32'd0);

    // R9 OE falls mid-strobe
    ce_n_i = 1'b0; we_n_i = 1'b0; addr_i = 17'h04444; idle(4);
    oe_n_i = 1'b0; idle(4);
    we_n_i = 1'b1; idle(2);
    oe_n_i = 1'b1; ce_n_i = 1'b1; idle(6);
    // R9 OE low throughout
    oe_n_i = 1'b0; ce_n_i = 1'b0; we_n_i = 1'b0; idle(5);
    we_n_i = 1'b1; ce_n_i = 1'b1; idle(2);
    oe_n_i = 1'b1; idle(6);
    check("R9 no pulse queue", expq.size(), 32'd0);

    wr_cyc(1'b1, 17'h10203, 8'hE7, 2, 1'b0, 1'b1);
    idle(4);
    check("R6 all writes seen", expq.size(), 32'd0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule